// File: doc/BRIEF.md
# Ring Neighbour Bank Access Arbiter

This block serves one node of a ring of processing units, each with its own memory bank. A unit may reach three banks: its own and those of its two ring neighbours. The block does two jobs at one node. On the requester side, it takes the local unit's request, decodes a 2-bit target field, and steers the request to one of three places: the local bank, the link towards the left neighbour, or the link towards the right neighbour. On the bank side, the local bank has a single port. The block arbitrates among the local unit and the two neighbouring units that want this bank, and forwards one request at a time.

Read responses from the bank come back in the order the reads were accepted. Each accepted read leaves a small source tag in a queue, and that tag sends the response to the requester that issued it. Each unit keeps at most one read in flight. As a result, responses from the three banks it can reach never collide on its single return path. The node's ring neighbour indices wrap around at the ends of the ring.

Top module: `ring_bank_port`

## Requirements
- R1: The requester target field selects the route: code 00 sends the request to the local arbiter, code 01 asserts `nl_valid` and code 10 asserts `nr_valid`. A request drives exactly one of these routes.
- R2: Target code 11 is illegal. With `u_valid` high it raises `u_err`, drives `u_ready` high so the request is dropped, and reaches no route.
- R3: `left_id` equals (NODE_ID + NODES - 1) mod NODES and `right_id` equals (NODE_ID + 1) mod NODES.
- R4: At most one source is granted the bank per cycle. The bank request carries the address, write flag and data of the granted source, and that source alone sees its ready high when `b_ready` is high.
- R5: Arbitration is round robin. Source numbering is local = 0, left = 1, right = 2. The search starts at the source after the one last accepted. After reset the order is local, left, right.
- R6: Once a source is offered to the bank, the grant stays with it, without re-arbitration, until `b_ready` accepts it.
- R7: The bank returns read responses in acceptance order. Each one raises only the issuing source's response valid (`u_rvalid` for local, `il_rvalid`, `ir_rvalid`), with `b_rdata`.
- R8: A requester whose ready is low keeps its request valid and unchanged until it is accepted.
- R9: Once the local unit's read is accepted on any route, `u_ready` stays low until that read's response arrives. Responses from the local bank, the left bank and the right bank all appear on `u_rvalid`/`u_rdata`.
- R10: While TAGQ_DEPTH read tags are outstanding, no request is offered to the bank. Offers resume in the cycle after a response is returned.
- R11: After reset, no bank request, response valid, error or inbound ready is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| left_id | output | $clog2(NODES) | Ring index of left neighbour |
| right_id | output | $clog2(NODES) | Ring index of right neighbour |
| u_valid | input | 1 | Local unit request valid |
| u_tgt | input | 2 | Target: 00 local, 01 left, 10 right, 11 illegal |
| u_we | input | 1 | Local unit write flag |
| u_addr | input | AW | Local unit word address |
| u_wdata | input | DW | Local unit write data |
| u_ready | output | 1 | Local unit request accepted |
| u_err | output | 1 | Illegal target flagged |
| u_rvalid | output | 1 | Read response to local unit |
| u_rdata | output | DW | Read data to local unit |
| nl_valid | output | 1 | Request towards left neighbour bank |
| nl_we | output | 1 | Write flag towards left |
| nl_addr | output | AW | Address towards left |
| nl_wdata | output | DW | Write data towards left |
| nl_ready | input | 1 | Left neighbour accepted |
| nl_rvalid | input | 1 | Response from left neighbour bank |
| nl_rdata | input | DW | Data from left neighbour bank |
| nr_valid | output | 1 | Request towards right neighbour bank |
| nr_we | output | 1 | Write flag towards right |
| nr_addr | output | AW | Address towards right |
| nr_wdata | output | DW | Write data towards right |
| nr_ready | input | 1 | Right neighbour accepted |
| nr_rvalid | input | 1 | Response from right neighbour bank |
| nr_rdata | input | DW | Data from right neighbour bank |
| il_valid | input | 1 | Left unit requests this bank |
| il_we | input | 1 | Left unit write flag |
| il_addr | input | AW | Left unit address |
| il_wdata | input | DW | Left unit write data |
| il_ready | output | 1 | Left unit request accepted |
| il_rvalid | output | 1 | Response to left unit |
| il_rdata | output | DW | Data to left unit |
| ir_valid | input | 1 | Right unit requests this bank |
| ir_we | input | 1 | Right unit write flag |
| ir_addr | input | AW | Right unit address |
| ir_wdata | input | DW | Right unit write data |
| ir_ready | output | 1 | Right unit request accepted |
| ir_rvalid | output | 1 | Response to right unit |
| ir_rdata | output | DW | Data to right unit |
| b_valid | output | 1 | Request to bank |
| b_we | output | 1 | Bank write flag |
| b_addr | output | AW | Bank address |
| b_wdata | output | DW | Bank write data |
| b_ready | input | 1 | Bank accepts request |
| b_rvalid | input | 1 | Bank read response valid |
| b_rdata | input | DW | Bank read data |

## Verification
The bench builds the block with NODES = 64 and NODE_ID = 0. With NODE_ID = 0 the left neighbour index has to wrap to the last node, 63. TAGQ_DEPTH is set to 2, so two overlapping reads from the neighbours fill the tag queue. That brings the stalled-offer case and its release within a few cycles. The bench also checks that the queued responses return, in order, to the right and left units. AW = 18 and DW = 32 give the 1 MB word-addressed bank.

// File: rtl/rnb_pkg.sv
package rnb_pkg;
    localparam int NSRC = 3;

    typedef enum logic [1:0] {
        SRC_OWN   = 2'd0,
        SRC_LEFT  = 2'd1,
        SRC_RIGHT = 2'd2
    } src_e;

    localparam logic [1:0] TGT_OWN   = 2'b00;
    localparam logic [1:0] TGT_LEFT  = 2'b01;
    localparam logic [1:0] TGT_RIGHT = 2'b10;
    localparam logic [1:0] TGT_BAD   = 2'b11;
endpackage

// File: rtl/rnb_req_decode.sv
module rnb_req_decode
    import rnb_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          u_valid,
    input  logic [1:0]    u_tgt,
    input  logic          u_we,
    input  logic          own_ready,
    input  logic          nl_ready,
    input  logic          nr_ready,
    input  logic          own_rvalid,
    input  logic [DW-1:0] own_rdata,
    input  logic          nl_rvalid,
    input  logic [DW-1:0] nl_rdata,
    input  logic          nr_rvalid,
    input  logic [DW-1:0] nr_rdata,
    output logic          own_req,
    output logic          nl_valid,
    output logic          nr_valid,
    output logic          u_ready,
    output logic          u_err,
    output logic          u_rvalid,
    output logic [DW-1:0] u_rdata
);
    typedef struct packed {
        logic pend;
    } dec_s;

    dec_s dec_d, dec_q;
    logic open;
    logic fire;

    always_comb begin
        dec_d    = dec_q;
        open     = u_valid && !dec_q.pend;
        own_req  = open && (u_tgt == TGT_OWN);
        nl_valid = open && (u_tgt == TGT_LEFT);
        nr_valid = open && (u_tgt == TGT_RIGHT);
        u_err    = u_valid && (u_tgt == TGT_BAD);
        case (u_tgt)
            TGT_OWN:   u_ready = !dec_q.pend && own_ready;
            TGT_LEFT:  u_ready = !dec_q.pend && nl_ready;
            TGT_RIGHT: u_ready = !dec_q.pend && nr_ready;
            default:   u_ready = 1'b1;
        endcase
        fire     = u_valid && u_ready && (u_tgt != TGT_BAD);
        u_rvalid = own_rvalid || nl_rvalid || nr_rvalid;
        if (own_rvalid)     u_rdata = own_rdata;
        else if (nl_rvalid) u_rdata = nl_rdata;
        else                u_rdata = nr_rdata;
        if (u_rvalid)          dec_d.pend = 1'b0;
        if (fire && !u_we)     dec_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    // R9: the three return paths never deliver together
    assert_one_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({own_rvalid, nl_rvalid, nr_rvalid}) <= 1);

    // R9: a response only arrives while a read is in flight
    assert_resp_expected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_q.pend |-> !(own_rvalid || nl_rvalid || nr_rvalid));
endmodule

// File: rtl/rnb_rr_arbiter.sv
module rnb_rr_arbiter
    import rnb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req,
    input  logic            en,
    input  logic            bank_ready,
    output logic            gvalid,
    output src_e            gsrc,
    output logic [NSRC-1:0] gnt
);
    typedef struct packed {
        src_e last;
        logic lock;
        src_e held;
    } arb_s;

    arb_s arb_d, arb_q;
    src_e pick;
    logic found;
    int   idx;

    always_comb begin
        arb_d = arb_q;
        pick  = arb_q.last;
        found = 1'b0;
        idx   = 0;
        for (int k = 1; k <= NSRC; k++) begin
            idx = (int'(arb_q.last) + k) % NSRC;
            if (!found && req[idx]) begin
                found = 1'b1;
                pick  = src_e'(idx[1:0]);
            end
        end
        if (arb_q.lock) begin
            gvalid = 1'b1;
            gsrc   = arb_q.held;
        end else begin
            gvalid = found && en;
            gsrc   = pick;
        end
        gnt = '0;
        if (gvalid) gnt[gsrc] = 1'b1;
        if (gvalid && bank_ready) begin
            arb_d.last = gsrc;
            arb_d.lock = 1'b0;
        end else if (gvalid) begin
            arb_d.lock = 1'b1;
            arb_d.held = gsrc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arb_q.last <= SRC_RIGHT;
            arb_q.lock <= 1'b0;
            arb_q.held <= SRC_OWN;
        end else begin
            arb_q <= arb_d;
        end
    end

    assert_grant_requested_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gvalid |-> req[gsrc]);

    assert_grant_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gvalid && !bank_ready) |=> (gvalid && gsrc == $past(gsrc)));

    assert_rotate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(gvalid && bank_ready) && !arb_q.lock && en && req == '1)
        |-> gsrc != $past(gsrc));
endmodule

// File: rtl/rnb_tag_fifo.sv
module rnb_tag_fifo
    import rnb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  src_e push_src,
    input  logic pop,
    output logic full,
    output src_e head
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][1:0] slot;
        logic [PW-1:0]         wr;
        logic [PW-1:0]         rd;
        logic [CW-1:0]         cnt;
    } tq_s;

    tq_s tq_d, tq_q;

    always_comb begin
        tq_d = tq_q;
        full = (tq_q.cnt == CW'(DEPTH));
        head = src_e'(tq_q.slot[tq_q.rd]);
        if (push) begin
            tq_d.slot[tq_q.wr] = push_src;
            tq_d.wr = (tq_q.wr == PW'(DEPTH - 1)) ? '0 : tq_q.wr + 1'b1;
        end
        if (pop) begin
            tq_d.rd = (tq_q.rd == PW'(DEPTH - 1)) ? '0 : tq_q.rd + 1'b1;
        end
        tq_d.cnt = tq_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tq_q <= '0;
        else        tq_q <= tq_d;
    end

    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> tq_q.cnt != '0);

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> tq_q.cnt < CW'(DEPTH));
endmodule

// File: rtl/ring_bank_port.sv
module ring_bank_port
    import rnb_pkg::*;
#(
    parameter int NODES      = 64,
    parameter int NODE_ID    = 0,
    parameter int AW         = 18,
    parameter int DW         = 32,
    parameter int TAGQ_DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    output logic [$clog2(NODES)-1:0] left_id,
    output logic [$clog2(NODES)-1:0] right_id,
    input  logic                     u_valid,
    input  logic [1:0]               u_tgt,
    input  logic                     u_we,
    input  logic [AW-1:0]            u_addr,
    input  logic [DW-1:0]            u_wdata,
    output logic                     u_ready,
    output logic                     u_err,
    output logic                     u_rvalid,
    output logic [DW-1:0]            u_rdata,
    output logic                     nl_valid,
    output logic                     nl_we,
    output logic [AW-1:0]            nl_addr,
    output logic [DW-1:0]            nl_wdata,
    input  logic                     nl_ready,
    input  logic                     nl_rvalid,
    input  logic [DW-1:0]            nl_rdata,
    output logic                     nr_valid,
    output logic                     nr_we,
    output logic [AW-1:0]            nr_addr,
    output logic [DW-1:0]            nr_wdata,
    input  logic                     nr_ready,
    input  logic                     nr_rvalid,
    input  logic [DW-1:0]            nr_rdata,
    input  logic                     il_valid,
    input  logic                     il_we,
    input  logic [AW-1:0]            il_addr,
    input  logic [DW-1:0]            il_wdata,
    output logic                     il_ready,
    output logic                     il_rvalid,
    output logic [DW-1:0]            il_rdata,
    input  logic                     ir_valid,
    input  logic                     ir_we,
    input  logic [AW-1:0]            ir_addr,
    input  logic [DW-1:0]            ir_wdata,
    output logic                     ir_ready,
    output logic                     ir_rvalid,
    output logic [DW-1:0]            ir_rdata,
    output logic                     b_valid,
    output logic                     b_we,
    output logic [AW-1:0]            b_addr,
    output logic [DW-1:0]            b_wdata,
    input  logic                     b_ready,
    input  logic                     b_rvalid,
    input  logic [DW-1:0]            b_rdata
);
    localparam int IDW      = $clog2(NODES);
    localparam int LEFT_ID  = (NODE_ID + NODES - 1) % NODES;
    localparam int RIGHT_ID = (NODE_ID + 1) % NODES;

    logic            own_req;
    logic            own_ready;
    logic            own_rvalid;
    logic            gvalid;
    src_e            gsrc;
    logic [NSRC-1:0] gnt;
    logic            tq_full;
    src_e            tq_head;
    logic            tq_push;

    assign left_id  = IDW'(LEFT_ID);
    assign right_id = IDW'(RIGHT_ID);

    assign nl_we    = u_we;
    assign nl_addr  = u_addr;
    assign nl_wdata = u_wdata;
    assign nr_we    = u_we;
    assign nr_addr  = u_addr;
    assign nr_wdata = u_wdata;

    rnb_req_decode #(.DW(DW)) i_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .u_valid    (u_valid),
        .u_tgt      (u_tgt),
        .u_we       (u_we),
        .own_ready  (own_ready),
        .nl_ready   (nl_ready),
        .nr_ready   (nr_ready),
        .own_rvalid (own_rvalid),
        .own_rdata  (b_rdata),
        .nl_rvalid  (nl_rvalid),
        .nl_rdata   (nl_rdata),
        .nr_rvalid  (nr_rvalid),
        .nr_rdata   (nr_rdata),
        .own_req    (own_req),
        .nl_valid   (nl_valid),
        .nr_valid   (nr_valid),
        .u_ready    (u_ready),
        .u_err      (u_err),
        .u_rvalid   (u_rvalid),
        .u_rdata    (u_rdata)
    );

    rnb_rr_arbiter i_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        ({ir_valid, il_valid, own_req}),
        .en         (!tq_full),
        .bank_ready (b_ready),
        .gvalid     (gvalid),
        .gsrc       (gsrc),
        .gnt        (gnt)
    );

    rnb_tag_fifo #(.DEPTH(TAGQ_DEPTH)) i_tagq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (tq_push),
        .push_src (gsrc),
        .pop      (b_rvalid),
        .full     (tq_full),
        .head     (tq_head)
    );

    always_comb begin
        b_valid = gvalid;
        case (gsrc)
            SRC_LEFT: begin
                b_we = il_we;  b_addr = il_addr;  b_wdata = il_wdata;
            end
            SRC_RIGHT: begin
                b_we = ir_we;  b_addr = ir_addr;  b_wdata = ir_wdata;
            end
            default: begin
                b_we = u_we;   b_addr = u_addr;   b_wdata = u_wdata;
            end
        endcase
        tq_push    = gvalid && b_ready && !b_we;
        own_ready  = gnt[SRC_OWN]   && b_ready;
        il_ready   = gnt[SRC_LEFT]  && b_ready;
        ir_ready   = gnt[SRC_RIGHT] && b_ready;
        own_rvalid = b_rvalid && (tq_head == SRC_OWN);
        il_rvalid  = b_rvalid && (tq_head == SRC_LEFT);
        ir_rvalid  = b_rvalid && (tq_head == SRC_RIGHT);
        il_rdata   = b_rdata;
        ir_rdata   = b_rdata;
    end

    assert_req_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (u_valid && !u_ready) |=> (u_valid && $stable(u_tgt) && $stable(u_addr)
                                   && $stable(u_we) && $stable(u_wdata)));

    assert_bad_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (u_valid && u_tgt == TGT_BAD) |-> (!nl_valid && !nr_valid && !gnt[SRC_OWN]));

    assert_resp_routed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        b_rvalid |-> $onehot({own_rvalid, il_rvalid, ir_rvalid}));
endmodule

// File: tb/test_ring_bank_port.sv
module test_ring_bank_port;
    localparam int CLK_P = 10;
    localparam int NODES = 64;
    localparam int AW    = 18;
    localparam int DW    = 32;

    // [11] u_valid [10:9] u_tgt [8] il_valid [7] ir_valid [6] b_ready
    // [5:4] expected source (3 = none) [3] exp u_err [2] exp nl_valid [1] exp u_ready
    localparam logic [11:0] VEC [12] = '{
        12'b1_00_1_1_1_00_0_0_1_0,  // R5 local first after reset
        12'b1_00_1_1_1_01_0_0_0_0,  // R5 then left
        12'b1_00_1_1_1_10_0_0_0_0,  // R5 then right
        12'b1_00_1_1_0_00_0_0_0_0,  // R6 local offered, bank stalls
        12'b1_00_1_1_0_00_0_0_0_0,  // R6 grant held, R8 request held
        12'b1_00_1_1_1_00_0_0_1_0,  // R6 accepted
        12'b0_00_0_1_1_10_0_0_0_0,  // R4 right alone
        12'b0_00_1_0_1_01_0_0_0_0,  // R4 left alone
        12'b1_00_1_0_1_00_0_0_1_0,  // R5 local after left
        12'b1_01_1_1_1_01_0_1_1_0,  // R1 unit routed left, left wins bank
        12'b0_00_0_0_1_11_0_0_0_0,  // idle
        12'b1_11_0_1_1_10_1_0_1_0   // R2 illegal target
    };

    logic clk = 1'b0;
    logic rst_n;
    logic [5:0] left_id, right_id;
    logic u_valid, u_we, u_ready, u_err, u_rvalid;
    logic [1:0] u_tgt;
    logic [AW-1:0] u_addr;
    logic [DW-1:0] u_wdata, u_rdata;
    logic nl_valid, nl_we, nl_ready, nl_rvalid;
    logic [AW-1:0] nl_addr;
    logic [DW-1:0] nl_wdata, nl_rdata;
    logic nr_valid, nr_we, nr_ready, nr_rvalid;
    logic [AW-1:0] nr_addr;
    logic [DW-1:0] nr_wdata, nr_rdata;
    logic il_valid, il_we, il_ready, il_rvalid;
    logic [AW-1:0] il_addr;
    logic [DW-1:0] il_wdata, il_rdata;
    logic ir_valid, ir_we, ir_ready, ir_rvalid;
    logic [AW-1:0] ir_addr;
    logic [DW-1:0] ir_wdata, ir_rdata;
    logic b_valid, b_we, b_ready, b_rvalid;
    logic [AW-1:0] b_addr;
    logic [DW-1:0] b_wdata, b_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    ring_bank_port #(.NODES(NODES), .NODE_ID(0), .AW(AW), .DW(DW), .TAGQ_DEPTH(2))
    i_ring_bank_port (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_P * 20000);
        n_bad++;
        $display("FAIL watchdog R11 act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        u_valid = 0; u_tgt = 0; u_we = 0; u_addr = 0; u_wdata = 0;
        nl_ready = 1; nl_rvalid = 0; nl_rdata = 0;
        nr_ready = 1; nr_rvalid = 0; nr_rdata = 0;
        il_valid = 0; il_we = 0; il_addr = 0; il_wdata = 0;
        ir_valid = 0; ir_we = 0; ir_addr = 0; ir_wdata = 0;
        b_ready = 0; b_rvalid = 0; b_rdata = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R11 b_valid", b_valid, 0);
        chk("R11 u_rvalid", u_rvalid, 0);
        chk("R11 u_err", u_err, 0);
        chk("R11 il_ready", il_ready, 0);
        chk("R3 left_id wraps", left_id, 63);
        chk("R3 right_id", right_id, 1);

        for (int i = 0; i < 12; i++) begin
            logic [11:0] v;
            v = VEC[i];
            cyc();
            u_valid = v[11]; u_tgt = v[10:9]; u_we = 1; u_addr = 1;
            il_valid = v[8]; il_we = 1; il_addr = 2;
            ir_valid = v[7]; ir_we = 1; ir_addr = 3;
            b_ready = v[6];
            @(negedge clk);
            chk("R5 R6 bank valid", b_valid, (v[5:4] != 2'b11));
            if (v[5:4] != 2'b11)
                chk("R4 R5 R6 granted address", b_addr, v[5:4] + 1);
            chk("R2 error flag", u_err, v[3]);
            chk("R1 left route", nl_valid, v[2]);
            chk("R4 unit ready", u_ready, v[1]);
        end

        // R4 R7: left read routed back to left
        cyc();
        u_valid = 0; ir_valid = 0; il_valid = 1; il_we = 0; il_addr = 5; b_ready = 1;
        @(negedge clk);
        chk("R4 left addr", {b_valid, b_addr}, {1'b1, 18'd5});
        chk("R4 left ready", il_ready, 1);
        cyc();
        il_valid = 0; b_rvalid = 1; b_rdata = 32'hA5A5_0001;
        @(negedge clk);
        chk("R7 left rvalid", il_rvalid, 1);
        chk("R7 left rdata", il_rdata, 32'hA5A5_0001);
        chk("R7 right quiet", ir_rvalid, 0);
        chk("R7 unit quiet", u_rvalid, 0);

        // R5 R7 R10: two reads fill the tag queue
        cyc();
        b_rvalid = 0;
        ir_valid = 1; ir_we = 0; ir_addr = 6;
        il_valid = 1; il_we = 0; il_addr = 7;
        @(negedge clk);
        chk("R5 right after left", b_addr, 6);
        cyc();
        ir_valid = 0;
        @(negedge clk);
        chk("R5 left next", b_addr, 7);
        cyc();
        il_valid = 0;
        u_valid = 1; u_tgt = 2'b00; u_we = 0; u_addr = 8;
        @(negedge clk);
        chk("R10 no offer when full", b_valid, 0);
        chk("R10 unit stalled", u_ready, 0);
        cyc();
        b_rvalid = 1; b_rdata = 32'h11;
        @(negedge clk);
        chk("R7 first to right", ir_rvalid, 1);
        chk("R7 not left", il_rvalid, 0);
        chk("R7 right data", ir_rdata, 32'h11);
        cyc();
        b_rdata = 32'h22;
        @(negedge clk);
        chk("R7 second to left", il_rvalid, 1);
        chk("R7 right quiet", ir_rvalid, 0);
        chk("R10 offer resumes", {b_valid, b_addr}, {1'b1, 18'd8});
        chk("R10 unit accepted", u_ready, 1);

        // R9: one outstanding read per unit
        cyc();
        b_rvalid = 0;
        u_tgt = 2'b10; u_addr = 9;
        @(negedge clk);
        chk("R9 blocked while pending", u_ready, 0);
        chk("R9 no right route", nr_valid, 0);
        cyc();
        b_rvalid = 1; b_rdata = 32'h33;
        @(negedge clk);
        chk("R9 local response", {u_rvalid, u_rdata}, {1'b1, 32'h33});
        chk("R9 still blocked", u_ready, 0);
        cyc();
        b_rvalid = 0;
        @(negedge clk);
        chk("R1 right route", nr_valid, 1);
        chk("R9 released", u_ready, 1);
        cyc();
        u_valid = 0; nr_rvalid = 1; nr_rdata = 32'h44;
        @(negedge clk);
        chk("R9 right response merged", {u_rvalid, u_rdata}, {1'b1, 32'h44});
        cyc();
        nr_rvalid = 0;

        // R8 R1: request to left held while neighbour stalls
        u_valid = 1; u_tgt = 2'b01; u_we = 1; u_addr = 18'h15; nl_ready = 0;
        @(negedge clk);
        chk("R1 left valid", nl_valid, 1);
        chk("R8 not ready while stalled", u_ready, 0);
        chk("R1 left address", nl_addr, 18'h15);
        cyc();
        nl_ready = 1;
        @(negedge clk);
        chk("R8 held request accepted", u_ready, 1);
        chk("R1 no bank offer", b_valid, 0);
        cyc();
        u_valid = 0;
        @(negedge clk);
        chk("R1 route idle", nl_valid, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule